// File: doc/BRIEF.md
# Clock halt and restart controller

This block decides whether the derived system clocks may run. It watches a three-bit processor status code on every rising edge of the processor clock, which arrives as a one-cycle strobe in the reference-clock domain. A stop is accepted only as a two-step sequence: one strobe reads the passive code and the next strobe reads the halt code. When a stop is accepted, the block withdraws the clock-run enable. The divider stages use that enable to freeze the processor and 50% clocks high and to hold the peripheral clock at its current level. In crystal mode the block also withdraws the oscillator enable, so the oscillator output parks high.

A restart comes from a rising edge on the start input or from the board reset input being low. Both inputs are first passed through two-flop synchronisers. With an external frequency source the clocks resume at once. With a crystal, the block re-enables the oscillator and then holds the clocks off for a full warm-up count before letting them run. The divider mode (slow or fast) is stored outside this block and is never touched by it, so the clocks come back in the mode they had when they stopped. The source select is a static strap.

Top module: `clk_halt_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the outputs are `clk_run_o`=1, `osc_en_o`=1 and `hold_o`=0.
- R2: `status_i` is sampled only on cycles where `pclk_rise_i` is 1 and only while the clocks run. Status values present without a strobe, or strobed while halted or warming up, have no effect on the outputs.
- R3: `status_i` carries the bits as {S2,S1,S0}. A stop is accepted on a strobe that reads 3'b011 when the preceding strobe read 3'b111. From the next cycle `clk_run_o`=0 and `hold_o`=1. A strobe reading 3'b011 without a preceding 3'b111 changes nothing.
- R4: With `ext_src_i`=0 (crystal), an accepted stop also drives `osc_en_o` to 0. With `ext_src_i`=1 (external source), `osc_en_o` stays 1 throughout.
- R5: While the synchronised `start_i` level is high, a stop sequence is not accepted.
- R6: In external-source mode, a rising edge of `start_i` while halted gives `clk_run_o`=1 and `hold_o`=0 after exactly three clock edges, counted from the first edge that samples `start_i` high.
- R7: In crystal mode, a rising edge of `start_i` while halted gives `osc_en_o`=1 and `hold_o`=0 after three edges. `clk_run_o` stays 0 for another WARM_CYCLES edges and rises on the last of them.
- R8: `sys_res_ni` held low, once synchronised, acts as a restart in the same way as a start edge (three edges). While it is low, a stop sequence is not accepted.
- R9: The warm-up count starts from zero on every crystal restart, so each crystal restart waits the full WARM_CYCLES.
- R10: A start edge while the clocks are running leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (oscillator or external source) |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pclk_rise_i | input | 1 | One-cycle strobe marking a processor-clock rising edge |
| status_i | input | 3 | Processor status {S2,S1,S0} |
| start_i | input | 1 | Asynchronous restart request, acts on its rising edge |
| sys_res_ni | input | 1 | Asynchronous board reset, active low, restarts the clocks |
| ext_src_i | input | 1 | Static source select: 1 external source, 0 crystal |
| clk_run_o | output | 1 | Enable for the derived clocks |
| osc_en_o | output | 1 | Oscillator run request |
| hold_o | output | 1 | High while halted and waiting for a restart |

## Verification
The sharpest collision is a stop sequence completing on the same edge at which a restart condition is present. The bench provokes this by holding `start_i` high, and in a separate case `sys_res_ni` low, across a passive-then-halt strobe pair. It then judges that the clocks stay running. A second overlap is a start edge arriving while the clocks already run, which must leave every output untouched. A behavioural model is compared on every cycle. Directed checks at the exact synchroniser and warm-up boundaries back it up, including a second crystal restart, which shows that the warm-up count starts again from zero.

// File: rtl/clk_halt_pkg.sv
package clk_halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WARM = 2'd2
  } run_state_e;

  localparam int unsigned STAT_W      = 3;
  localparam logic [2:0]  STAT_PASSIVE = 3'b111;
  localparam logic [2:0]  STAT_HALT    = 3'b011;
endpackage

// File: rtl/chc_sync.sv
module chc_sync #(
  parameter int unsigned         W       = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/chc_stop_detect.sv
module chc_stop_detect
  import clk_halt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              pclk_rise_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              block_i,
  output logic              stop_o
);
  logic prev_passive_q;

  // R2: history only advances on strobes while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          prev_passive_q <= 1'b0;
    else if (!arm_i)      prev_passive_q <= 1'b0;
    else if (pclk_rise_i) prev_passive_q <= (status_i == STAT_PASSIVE);
  end

  // R3, R5, R8
  assign stop_o = arm_i && pclk_rise_i && !block_i && prev_passive_q
                  && (status_i == STAT_HALT);
endmodule

// File: rtl/chc_warm_timer.sv
module chc_warm_timer #(
  parameter int unsigned CYCLES = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tc_o
);
  localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // R9: cleared whenever not warming
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (!tc_o)     cnt_q <= cnt_q + 1'b1;
  end

  assign tc_o = en_i && (cnt_q == LAST);

  a_r9_warm_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (cnt_q == '0));
endmodule

// File: rtl/clk_halt_ctrl.sv
module clk_halt_ctrl
  import clk_halt_pkg::*;
#(
  parameter int unsigned WARM_CYCLES = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk_rise_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              start_i,
  input  logic              sys_res_ni,
  input  logic              ext_src_i,
  output logic              clk_run_o,
  output logic              osc_en_o,
  output logic              hold_o
);
  run_state_e state_q, state_d;
  logic [1:0] sync_q;
  logic       start_s, res_n_s, start_d_q;
  logic       start_rise, res_act, restart, blk, stop, warm_tc;

  chc_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({start_i, sys_res_ni}),
    .q_o   (sync_q)
  );
  assign start_s = sync_q[1];
  assign res_n_s = sync_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_d_q <= 1'b0;
    else         start_d_q <= start_s;
  end

  assign start_rise = start_s && !start_d_q;
  assign res_act    = !res_n_s;
  assign restart    = start_rise || res_act;
  assign blk        = start_s || res_act;

  chc_stop_detect u_stop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (state_q == ST_RUN),
    .pclk_rise_i(pclk_rise_i),
    .status_i   (status_i),
    .block_i    (blk),
    .stop_o     (stop)
  );

  chc_warm_timer #(.CYCLES(WARM_CYCLES)) u_warm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == ST_WARM),
    .tc_o  (warm_tc)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (stop) state_d = ST_HALT;
      ST_HALT: if (restart) state_d = ext_src_i ? ST_RUN : ST_WARM;
      ST_WARM: if (warm_tc) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign clk_run_o = (state_q == ST_RUN);
  assign hold_o    = (state_q == ST_HALT);
  assign osc_en_o  = ext_src_i || (state_q != ST_HALT);

  a_r3_stop_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_run_o && pclk_rise_i && status_i == STAT_HALT && !blk
     && u_stop.prev_passive_q) |=> (hold_o && !clk_run_o));

  a_r6_halt_waits_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !restart) |=> hold_o);

  a_r7_warm_until_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WARM && !warm_tc) |=> (!clk_run_o && !hold_o));

  a_r4_xtal_halt_osc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_run_o && !ext_src_i && stop) |=> !osc_en_o);
endmodule

// File: tb/clk_halt_ctrl_test.sv
module clk_halt_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WARM_N     = 8192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pclk_rise = 1'b0;
  logic [2:0] status = 3'b111;
  logic       start = 1'b0;
  logic       res_n = 1'b1;
  logic       ext = 1'b0;
  logic       run_o, osc_o, hold_o;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 1'b0;
  bit    model_on = 1'b0;
  string cur_tag  = "R1";

  int m_st, m_wait;
  bit m_prev, ms1, ms2, ms_old, mr1, mr2;
  bit s_lvl, s_rise, r_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_halt_ctrl #(.WARM_CYCLES(WARM_N)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pclk_rise_i(pclk_rise),
    .status_i   (status),
    .start_i    (start),
    .sys_res_ni (res_n),
    .ext_src_i  (ext),
    .clk_run_o  (run_o),
    .osc_en_o   (osc_o),
    .hold_o     (hold_o)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: {run,osc,hold} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 run, 1 halted, 2 warming
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_wait = 0; m_prev = 0;
      ms1 = 0; ms2 = 0; ms_old = 0; mr1 = 1; mr2 = 1;
    end else begin
      s_lvl  = ms2;
      s_rise = ms2 && !ms_old;
      r_act  = !mr2;
      if (m_st == 0) begin
        if (pclk_rise) begin
          if (status == 3'b011 && m_prev && !s_lvl && !r_act) begin
            m_st = 1; m_prev = 0;
          end else m_prev = (status == 3'b111);
        end
      end else if (m_st == 1) begin
        if (s_rise || r_act) begin
          if (ext) m_st = 0;
          else begin m_st = 2; m_wait = 0; end
        end
      end else begin
        if (m_wait == WARM_N - 1) m_st = 0;
        else m_wait++;
      end
      ms_old = ms2; ms2 = ms1; ms1 = start;
      mr2 = mr1; mr1 = res_n;
    end
    #(CLK_PERIOD/4);
    if (model_on)
      check(cur_tag, {run_o, osc_o, hold_o},
            {m_st == 0, !(m_st == 1 && !ext), m_st == 1});
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [2:0] s);
    status = s; pclk_rise = 1'b1;
    @(negedge clk);
    pclk_rise = 1'b0;
  endtask

  task automatic do_stop();
    strobe(3'b111);
    cyc(2);
    strobe(3'b011);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {run_o, osc_o, hold_o}, 3'b110);
    model_on = 1'b1;

    cur_tag = "R3";
    strobe(3'b101); strobe(3'b011);
    check("R3", {run_o, osc_o, hold_o}, 3'b110);

    cur_tag = "R2";
    strobe(3'b010);
    status = 3'b111; cyc(2);
    strobe(3'b011);
    check("R2", {run_o, osc_o, hold_o}, 3'b110);

    cur_tag = "R4";
    do_stop();
    check("R3", {run_o, osc_o, hold_o}, 3'b001);
    check("R4", {run_o, osc_o, hold_o}, 3'b001);

    cur_tag = "R2";
    strobe(3'b111); strobe(3'b011);
    check("R2", {run_o, osc_o, hold_o}, 3'b001);

    cur_tag = "R7";
    start = 1'b1;
    cyc(2);
    check("R7", {run_o, osc_o, hold_o}, 3'b001);
    cyc(1);
    check("R7", {run_o, osc_o, hold_o}, 3'b010);
    strobe(3'b111); strobe(3'b011);
    check("R2", {run_o, osc_o, hold_o}, 3'b010);
    cyc(WARM_N - 3);
    check("R7", {run_o, osc_o, hold_o}, 3'b010);
    cyc(1);
    check("R7", {run_o, osc_o, hold_o}, 3'b110);

    cur_tag = "R5";
    strobe(3'b111); strobe(3'b011);
    check("R5", {run_o, osc_o, hold_o}, 3'b110);
    start = 1'b0; cyc(4);

    cur_tag = "R10";
    start = 1'b1; cyc(4);
    check("R10", {run_o, osc_o, hold_o}, 3'b110);
    start = 1'b0; cyc(4);

    cur_tag = "R4";
    ext = 1'b1; cyc(1);
    do_stop();
    check("R4", {run_o, osc_o, hold_o}, 3'b011);

    cur_tag = "R6";
    start = 1'b1;
    cyc(2);
    check("R6", {run_o, osc_o, hold_o}, 3'b011);
    cyc(1);
    check("R6", {run_o, osc_o, hold_o}, 3'b110);
    start = 1'b0; cyc(4);

    cur_tag = "R8";
    do_stop();
    check("R8", {run_o, osc_o, hold_o}, 3'b011);
    res_n = 1'b0;
    cyc(2);
    check("R8", {run_o, osc_o, hold_o}, 3'b011);
    cyc(1);
    check("R8", {run_o, osc_o, hold_o}, 3'b110);
    strobe(3'b111); strobe(3'b011);
    check("R8", {run_o, osc_o, hold_o}, 3'b110);
    res_n = 1'b1; cyc(4);

    cur_tag = "R9";
    ext = 1'b0; cyc(1);
    do_stop();
    check("R4", {run_o, osc_o, hold_o}, 3'b001);
    start = 1'b1; cyc(3);
    check("R9", {run_o, osc_o, hold_o}, 3'b010);
    cyc(2);
    check("R9", {run_o, osc_o, hold_o}, 3'b010);
    start = 1'b0;
    cyc(WARM_N - 3);
    check("R9", {run_o, osc_o, hold_o}, 3'b010);
    cyc(1);
    check("R9", {run_o, osc_o, hold_o}, 3'b110);

    cur_tag = "R8";
    do_stop();
    res_n = 1'b0; cyc(3);
    check("R8", {run_o, osc_o, hold_o}, 3'b010);
    res_n = 1'b1;
    cyc(WARM_N);
    check("R8", {run_o, osc_o, hold_o}, 3'b110);

    model_on = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule